// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a fully associative translation buffer. Each of its slots maps a virtual page number to a physical page number and carries an 8-bit address-space tag, a global flag, read-enable and write-enable masks with one bit per processor mode, and fault-on-read and fault-on-write flags. A lookup is purely combinational: the caller presents a page number and the current address-space tag, and in the same cycle gets a hit indication, the physical page and the permission fields of the matching slot.

New mappings are written at the slot named by a rotating victim pointer. Three flush commands are provided: one clears the whole buffer, one drops only the process-private (non-global) slots, and one drops the slots that map a single page for a given address space. Page-table walking, fault generation and counters belong to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: A lookup hits only when some slot is valid, its stored page number equals `lk_vpn`, and either its global flag is set or its stored tag equals `lk_asn`.
- R2: On a miss, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd`, `lk_fault_wr` and `lk_global` are all zero.
- R3: An insert writes the slot named by the victim pointer, replacing any valid mapping there, marks it valid, and advances the pointer by one, wrapping from slot ENTRIES-1 to slot 0.
- R4: When several slots match, the outputs come from the lowest-indexed matching slot.
- R5: Flush-all invalidates every slot and returns the victim pointer to slot 0.
- R6: Process flush invalidates only slots whose global flag is clear; global slots keep translating and the victim pointer keeps its value.
- R7: Address flush invalidates every valid slot whose page number equals `fl_vpn` and that is global or carries `fl_asn`; other slots are untouched.
- R8: Commands take effect at the clock edge, with priority flush-all, then process flush, then address flush, then insert; a lookup in the same cycle sees the state from before the edge.
- R9: While reset is asserted the buffer is emptied and the victim pointer set to 0.
- R10: On a hit, `lk_rd_en`/`lk_wr_en` bit m is the stored permission for mode m (0 kernel, 1 executive, 2 supervisor, 3 user), and the fault flags are the stored ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Page number to translate |
| lk_asn | input | ASN_W | Current address-space tag |
| lk_hit | output | 1 | A slot matches |
| lk_ppn | output | PPN_W | Physical page of the match |
| lk_rd_en | output | MODES | Read-enable per mode |
| lk_wr_en | output | MODES | Write-enable per mode |
| lk_fault_rd | output | 1 | Fault-on-read flag |
| lk_fault_wr | output | 1 | Fault-on-write flag |
| lk_global | output | 1 | Global flag of the match |
| ins_en | input | 1 | Insert a mapping |
| ins_vpn | input | VPN_W | Page number to insert |
| ins_asn | input | ASN_W | Tag of the inserted mapping |
| ins_global | input | 1 | Global flag of the inserted mapping |
| ins_ppn | input | PPN_W | Physical page to insert |
| ins_rd_en | input | MODES | Read-enable mask to insert |
| ins_wr_en | input | MODES | Write-enable mask to insert |
| ins_fault_rd | input | 1 | Fault-on-read flag to insert |
| ins_fault_wr | input | 1 | Fault-on-write flag to insert |
| fl_all | input | 1 | Flush every slot |
| fl_proc | input | 1 | Flush non-global slots |
| fl_addr | input | 1 | Flush one page |
| fl_vpn | input | VPN_W | Page for the address flush |
| fl_asn | input | ASN_W | Tag for the address flush |

## Verification
On every cycle the assertions check the consequences of each command visible in the next cycle: a lookup of a freshly inserted page hits, nothing hits after flush-all, only global slots can hit after a process flush, the flushed page misses for its own tag after an address flush, and the victim pointer advances, wraps, holds or returns to zero as each command demands. Which slot a replacement lands in, the lowest-index rule among duplicates, the survival of untouched slots and the permission fields only show through the bench's scenarios, which fill the buffer past wrap-around and place duplicates at chosen slots.

// File: rtl/asid_tlb.sv
module asid_tlb #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ASN_W   = 8,
  parameter int MODES   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [ASN_W-1:0] lk_asn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  output logic [MODES-1:0] lk_rd_en,
  output logic [MODES-1:0] lk_wr_en,
  output logic             lk_fault_rd,
  output logic             lk_fault_wr,
  output logic             lk_global,
  input  logic             ins_en,
  input  logic [VPN_W-1:0] ins_vpn,
  input  logic [ASN_W-1:0] ins_asn,
  input  logic             ins_global,
  input  logic [PPN_W-1:0] ins_ppn,
  input  logic [MODES-1:0] ins_rd_en,
  input  logic [MODES-1:0] ins_wr_en,
  input  logic             ins_fault_rd,
  input  logic             ins_fault_wr,
  input  logic             fl_all,
  input  logic             fl_proc,
  input  logic             fl_addr,
  input  logic [VPN_W-1:0] fl_vpn,
  input  logic [ASN_W-1:0] fl_asn
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] vld, glb, frd, fwr;
  logic [VPN_W-1:0]   tag  [ENTRIES];
  logic [ASN_W-1:0]   asn  [ENTRIES];
  logic [PPN_W-1:0]   ppn  [ENTRIES];
  logic [MODES-1:0]   rde  [ENTRIES];
  logic [MODES-1:0]   wre  [ENTRIES];
  logic [IDX_W-1:0]   vptr;

  logic [ENTRIES-1:0] lk_match, fl_match;

  wire do_all  = fl_all;
  wire do_proc = !fl_all && fl_proc;
  wire do_addr = !fl_all && !fl_proc && fl_addr;
  wire do_ins  = !fl_all && !fl_proc && !fl_addr && ins_en;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign lk_match[g] = vld[g] && tag[g] == lk_vpn && (glb[g] || asn[g] == lk_asn);
    assign fl_match[g] = vld[g] && tag[g] == fl_vpn && (glb[g] || asn[g] == fl_asn);
  end

  logic [IDX_W-1:0] sel;
  always_comb begin
    sel = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (lk_match[i]) sel = IDX_W'(i);
  end

  assign lk_hit      = |lk_match;
  assign lk_ppn      = lk_hit ? ppn[sel] : '0;
  assign lk_rd_en    = lk_hit ? rde[sel] : '0;
  assign lk_wr_en    = lk_hit ? wre[sel] : '0;
  assign lk_fault_rd = lk_hit && frd[sel];
  assign lk_fault_wr = lk_hit && fwr[sel];
  assign lk_global   = lk_hit && glb[sel];

  always_ff @(posedge clk) begin
    if (!rst_n || do_all) begin
      vptr <= '0;
      vld  <= '0;
      glb  <= '0;
      frd  <= '0;
      fwr  <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tag[i] <= '0;
        asn[i] <= '0;
        ppn[i] <= '0;
        rde[i] <= '0;
        wre[i] <= '0;
      end
    end else if (do_proc) begin
      vld <= vld & glb;
    end else if (do_addr) begin
      vld <= vld & ~fl_match;
    end else if (do_ins) begin
      vld[vptr]  <= 1'b1;
      glb[vptr]  <= ins_global;
      frd[vptr]  <= ins_fault_rd;
      fwr[vptr]  <= ins_fault_wr;
      tag[vptr]  <= ins_vpn;
      asn[vptr]  <= ins_asn;
      ppn[vptr]  <= ins_ppn;
      rde[vptr]  <= ins_rd_en;
      wre[vptr]  <= ins_wr_en;
      vptr       <= (vptr == LAST) ? '0 : vptr + 1'b1;
    end
  end

  a_r3_insert_visible: assert property (@(posedge clk) disable iff (!rst_n)
    do_ins |=> ((lk_vpn == $past(ins_vpn) && lk_asn == $past(ins_asn)) -> lk_hit));

  a_r3_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    do_ins |=> vptr == (($past(vptr) == LAST) ? '0 : $past(vptr) + 1'b1));

  a_r5_flush_all_empty: assert property (@(posedge clk) disable iff (!rst_n)
    fl_all |=> (!lk_hit && vptr == '0));

  a_r6_proc_keeps_global: assert property (@(posedge clk) disable iff (!rst_n)
    do_proc |=> (!lk_hit || lk_global));

  a_r6_proc_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    do_proc |=> $stable(vptr));

  a_r7_addr_gone: assert property (@(posedge clk) disable iff (!rst_n)
    do_addr |=> ((lk_vpn == $past(fl_vpn) && lk_asn == $past(fl_asn)) -> !lk_hit));

  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0 && lk_rd_en == '0 && lk_wr_en == '0 && !lk_global));
endmodule

// File: tb/asid_tlb_bench.sv
module asid_tlb_bench;
  localparam int N = 16;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [19:0] lk_vpn = 0, ins_vpn = 0, fl_vpn = 0, lk_ppn, ins_ppn = 0;
  logic [7:0]  lk_asn = 0, ins_asn = 0, fl_asn = 0;
  logic [3:0]  lk_rd_en, lk_wr_en, ins_rd_en = 0, ins_wr_en = 0;
  logic lk_hit, lk_fault_rd, lk_fault_wr, lk_global;
  logic ins_en = 0, ins_global = 0, ins_fault_rd = 0, ins_fault_wr = 0;
  logic fl_all = 0, fl_proc = 0, fl_addr = 0;

  asid_tlb u_asid_tlb (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  typedef enum logic [2:0] {OP_LK, OP_INS, OP_ALL, OP_PROC, OP_ADDR} op_t;
  typedef struct packed {
    op_t         op;
    logic [19:0] vpn;
    logic [7:0]  asn;
    logic        g;
    logic [19:0] ppn;
    logic        hit;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{OP_LK,   20'h100, 8'd1, 1'b0, 20'h0,   1'b0},
    '{OP_INS,  20'h100, 8'd1, 1'b0, 20'h0A1, 1'b0},
    '{OP_LK,   20'h100, 8'd1, 1'b0, 20'h0A1, 1'b1},
    '{OP_LK,   20'h100, 8'd2, 1'b0, 20'h0,   1'b0},
    '{OP_INS,  20'h200, 8'd5, 1'b1, 20'h3B2, 1'b0},
    '{OP_LK,   20'h200, 8'd9, 1'b0, 20'h3B2, 1'b1},
    '{OP_INS,  20'h100, 8'd2, 1'b0, 20'h1C3, 1'b0},
    '{OP_LK,   20'h100, 8'd2, 1'b0, 20'h1C3, 1'b1},
    '{OP_LK,   20'h100, 8'd1, 1'b0, 20'h0A1, 1'b1},
    '{OP_PROC, 20'h0,   8'd0, 1'b0, 20'h0,   1'b0},
    '{OP_LK,   20'h100, 8'd1, 1'b0, 20'h0,   1'b0},
    '{OP_LK,   20'h200, 8'd3, 1'b0, 20'h3B2, 1'b1},
    '{OP_INS,  20'h300, 8'd4, 1'b0, 20'h2D4, 1'b0},
    '{OP_ADDR, 20'h200, 8'd7, 1'b0, 20'h0,   1'b0},
    '{OP_LK,   20'h200, 8'd5, 1'b0, 20'h0,   1'b0},
    '{OP_LK,   20'h300, 8'd4, 1'b0, 20'h2D4, 1'b1},
    '{OP_INS,  20'h300, 8'd4, 1'b0, 20'h0E5, 1'b0},
    '{OP_LK,   20'h300, 8'd4, 1'b0, 20'h2D4, 1'b1},
    '{OP_ADDR, 20'h300, 8'd9, 1'b0, 20'h0,   1'b0},
    '{OP_LK,   20'h300, 8'd4, 1'b0, 20'h2D4, 1'b1},
    '{OP_ALL,  20'h0,   8'd0, 1'b0, 20'h0,   1'b0},
    '{OP_LK,   20'h300, 8'd4, 1'b0, 20'h0,   1'b0}
  };

  // permission fields are derived from the page: rd=ppn[3:0], wr=ppn[7:4], frd=ppn[8], fwr=ppn[9]
  task automatic insert(input logic [19:0] v, input logic [7:0] a, input logic g, input logic [19:0] p);
    @(negedge clk);
    ins_en = 1; ins_vpn = v; ins_asn = a; ins_global = g; ins_ppn = p;
    ins_rd_en = p[3:0]; ins_wr_en = p[7:4]; ins_fault_rd = p[8]; ins_fault_wr = p[9];
    @(negedge clk);
    ins_en = 0;
  endtask

  task automatic flush(input op_t op, input logic [19:0] v, input logic [7:0] a);
    @(negedge clk);
    fl_all = (op == OP_ALL); fl_proc = (op == OP_PROC); fl_addr = (op == OP_ADDR);
    fl_vpn = v; fl_asn = a;
    @(negedge clk);
    fl_all = 0; fl_proc = 0; fl_addr = 0;
  endtask

  task automatic check(input string req, input logic [19:0] v, input logic [7:0] a,
                       input logic eh, input logic eg, input logic [19:0] ep);
    logic [31:0] got, exp;
    lk_vpn = v; lk_asn = a;
    #1;
    got = {lk_hit, lk_global, lk_fault_wr, lk_fault_rd, lk_wr_en, lk_rd_en, lk_ppn};
    exp = eh ? {1'b1, eg, ep[9], ep[8], ep[7:4], ep[3:0], ep} : 32'h0;
    got[31:30] = 2'b00 | got[31:30]; exp[31:30] = 2'b00 | exp[31:30];
    n_chk++;
    if (got[29:0] != exp[29:0]) begin
      n_bad++;
      $display("FAIL %s vpn=%h asn=%0d actual=%h expected=%h", req, v, a, got[29:0], exp[29:0]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R2 R4 R6 R7 R10 table
    for (int i = 0; i < NV; i++) begin
      case (VECS[i].op)
        OP_LK:  begin @(negedge clk); check("R1/R2/R4/R6/R7/R10", VECS[i].vpn, VECS[i].asn,
                  VECS[i].hit, VECS[i].ppn == 20'h3B2, VECS[i].ppn); end
        OP_INS: insert(VECS[i].vpn, VECS[i].asn, VECS[i].g, VECS[i].ppn);
        default: flush(VECS[i].op, VECS[i].vpn, VECS[i].asn);
      endcase
    end
    // R6: pointer unchanged by process flush; global slot 0 survives 14 later inserts
    insert(20'h0A0, 8'd1, 1'b1, 20'h011);
    insert(20'h0B0, 8'd1, 1'b0, 20'h022);
    flush(OP_PROC, 0, 0);
    for (int i = 0; i < 14; i++) insert(20'h600 + 20'(i), 8'd3, 1'b0, 20'h100 + 20'(i));
    @(negedge clk);
    check("R6", 20'h0A0, 8'd7, 1, 1, 20'h011);
    check("R6", 20'h0B0, 8'd1, 0, 0, 0);
    for (int i = 0; i < 14; i++) check("R3", 20'h600 + 20'(i), 8'd3, 1, 0, 20'h100 + 20'(i));
    // R3 wrap: next insert lands in slot 0
    insert(20'h700, 8'd3, 1'b0, 20'h0F0);
    @(negedge clk);
    check("R3", 20'h0A0, 8'd7, 0, 0, 0);
    check("R3", 20'h700, 8'd3, 1, 0, 20'h0F0);
    check("R3", 20'h600, 8'd3, 1, 0, 20'h100);
    // move pointer to slot 15, then R5: flush-all returns it to 0 (duplicate order shows it)
    for (int i = 0; i < 14; i++) insert(20'h900 + 20'(i), 8'd3, 1'b0, 20'h0);
    flush(OP_ALL, 0, 0);
    @(negedge clk);
    check("R5", 20'h900, 8'd3, 0, 0, 0);
    insert(20'h800, 8'd2, 1'b0, 20'h155);
    insert(20'h800, 8'd2, 1'b0, 20'h2AA);
    @(negedge clk);
    check("R5", 20'h800, 8'd2, 1, 0, 20'h155);
    // R8: same-cycle lookup sees old state; flush beats insert
    @(negedge clk);
    ins_en = 1; ins_vpn = 20'hA00; ins_asn = 8'd4; ins_global = 0; ins_ppn = 20'h0C0;
    ins_rd_en = 4'h0; ins_wr_en = 4'hC; ins_fault_rd = 0; ins_fault_wr = 0;
    check("R8", 20'hA00, 8'd4, 0, 0, 0);
    @(negedge clk);
    check("R8", 20'hA00, 8'd4, 1, 0, 20'h0C0);
    ins_vpn = 20'hB00; fl_addr = 1; fl_vpn = 20'hA00; fl_asn = 8'd4;
    @(negedge clk);
    ins_en = 0; fl_addr = 0;
    check("R8", 20'hB00, 8'd4, 0, 0, 0);
    check("R8", 20'hA00, 8'd4, 0, 0, 0);
    check("R8", 20'h800, 8'd2, 1, 0, 20'h155);
    // R9: reset empties the buffer
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    check("R9", 20'h800, 8'd2, 0, 0, 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule